// File: doc/BRIEF.md
# Two-Channel Audio Word Serializer

This block takes a pair of 24-bit audio samples, one for the left channel and one for the right, and drives them bit by bit onto a single serial data output. Its bit clock and frame clock are not generated here: both arrive from outside and are brought into the system clock domain by two-flop synchronizers. The serial line changes only after a detected falling bit-clock edge. A receiver that samples on the rising bit-clock edge therefore sees stable data.

Two framings are supported. In the one-bit-delayed framing (I2S), a low frame clock marks the left slot, and the most significant bit follows one bit period after each frame-clock transition. In the left-justified framing, a high frame clock marks the left slot, and the most significant bit occupies the first bit period after the transition. The framing is chosen by a strap level. The strap is captured once, on the first system clock after reset is released, and is then kept until the next reset. After bit 0 of a word, the line is held low until the next frame-clock transition.

Samples are offered with a one-cycle valid strobe and go into a holding pair. At the start of every left slot the holding pair is copied into the active pair. A new pair therefore takes effect at the next frame boundary. If no new pair has arrived, the last pair is sent again.

The control state machine has four states:
- IDLE: the state after reset, until the first frame-clock transition. The line is held low.
- DELAY: the one-bit gap of the delayed framing. The line is held low.
- SHIFT: bits are sent from 23 down to 0.
- PAD: the line is held low after bit 0.

The transitions are as follows:
- Any frame-clock transition moves the machine to DELAY in the delayed framing, or to SHIFT in the left-justified framing.
- From DELAY, the next bit-clock fall moves the machine to SHIFT.
- In SHIFT, the fall that follows bit 0 moves the machine to PAD.
- IDLE and PAD hold until a frame-clock transition.

Top module: `audio_ser_top`

## Requirements
- R1: A high strap level captured at start-up selects the delayed (I2S) framing. A low level selects left-justified framing.
- R2: The strap is captured on the first system clock after reset is released. Later changes on the strap have no effect until the next reset.
- R3: Each channel word is sent most significant bit first, from bit 23 down to bit 0, one bit per bit-clock period.
- R4: In left-justified framing, a high frame clock marks the left slot, and bit 23 is driven in the first bit period after a frame-clock transition.
- R5: In the delayed framing, a low frame clock marks the left slot. The first bit period after a frame-clock transition drives 0, and bit 23 follows in the second period.
- R6: After bit 0 of a slot, the output is 0 in every bit period until the next frame-clock transition.
- R7: A pair offered with the valid strobe is used from the start of the next left slot. A pair offered during a frame does not change that frame's right word.
- R8: At a left slot start with no new pair since the last load, the previous pair is sent again.
- R9: In reset, and after reset until the first frame-clock transition seen at a bit-clock fall, the output is 0.
- R10: The output changes only on the system clock that follows a detected bit-clock falling edge, so it is stable across the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | External bit clock, asynchronous |
| lrck_in | input | 1 | External frame clock, asynchronous |
| fmt_strap | input | 1 | Framing strap: 1 selects delayed framing, 0 selects left-justified |
| pair_valid | input | 1 | One-cycle strobe that captures pair_left and pair_right |
| pair_left | input | 24 | Left-channel sample |
| pair_right | input | 24 | Right-channel sample |
| sdata_out | output | 1 | Serial data |

## Verification
The state machine is the main risk, and almost every fault in it shows up on the serial line within one bit period. A bit counter that is off by one shifts every bit of the word. A wrong delay state shows a premature most significant bit at the first period after a frame-clock edge. A missed pad state leaks stale bits into the tail of the slot. An error in the holding or active pair shows up one frame later, as the wrong word or as a word that fails to repeat. A strap that is wrongly re-latched flips the framing within one slot after the strap moves. The bench compares the line against a behavioural model twice per bit period, once before the rising edge and once after it.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SHIFT = 2'd2,
        ST_PAD   = 2'd3
    } ser_state_t;

endpackage

// File: rtl/audio_ser_sync.sv
module audio_ser_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
            end
        end
        assign sync_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/audio_ser_fmt_latch.sv
module audio_ser_fmt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    output logic fmt_valid,
    output logic fmt_i2s
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_valid <= 1'b0;
            fmt_i2s   <= 1'b0;
        end else if (!fmt_valid) begin
            fmt_valid <= 1'b1;
            fmt_i2s   <= strap;
        end
    end

endmodule

// File: rtl/audio_ser_shifter.sv
module audio_ser_shifter
    import audio_ser_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_s,
    input  logic                lrck_s,
    input  logic                fmt_valid,
    input  logic                fmt_i2s,
    input  logic                pair_valid,
    input  logic [SAMPLE_W-1:0] pair_left,
    input  logic [SAMPLE_W-1:0] pair_right,
    output logic                sdata,
    output ser_state_t          state_o,
    output logic                sclk_ev_o
);

    localparam int CNT_W = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] MSB_IDX = CNT_W'(SAMPLE_W - 1);

    ser_state_t          state, nxt;
    logic                sclk_q;
    logic                lr_q, lr_seen;
    logic                chan_left;
    logic [CNT_W-1:0]    bit_idx;
    logic [SAMPLE_W-1:0] hold_l, hold_r, act_l, act_r;
    logic                ev, lr_edge, slot_left, load;
    logic [SAMPLE_W-1:0] word_now;

    // Event decode: a falling bit-clock edge, and a frame-clock transition seen at that edge
    assign ev        = sclk_q && !sclk_s && fmt_valid;
    assign lr_edge   = ev && lr_seen && (lrck_s != lr_q);
    assign slot_left = fmt_i2s ? !lrck_s : lrck_s;
    assign load      = lr_edge && slot_left;

    always_comb begin
        if (lr_edge) begin
            word_now = slot_left ? hold_l : act_r;
        end else begin
            word_now = chan_left ? act_l : act_r;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (ev) begin
            if (lr_edge) begin
                nxt = fmt_i2s ? ST_DELAY : ST_SHIFT;
            end else begin
                unique case (state)
                    ST_IDLE:  nxt = ST_IDLE;
                    ST_DELAY: nxt = ST_SHIFT;
                    ST_SHIFT: nxt = (bit_idx == '0) ? ST_PAD : ST_SHIFT;
                    ST_PAD:   nxt = ST_PAD;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Edge tracking and sample capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            lr_q    <= 1'b0;
            lr_seen <= 1'b0;
            hold_l  <= '0;
            hold_r  <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (ev) begin
                lr_q    <= lrck_s;
                lr_seen <= 1'b1;
            end
            if (pair_valid) begin
                hold_l <= pair_left;
                hold_r <= pair_right;
            end
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata     <= 1'b0;
            bit_idx   <= '0;
            chan_left <= 1'b0;
            act_l     <= '0;
            act_r     <= '0;
        end else if (ev) begin
            if (lr_edge) begin
                chan_left <= slot_left;
            end
            if (load) begin
                act_l <= hold_l;
                act_r <= hold_r;
            end
            unique case (nxt)
                ST_IDLE, ST_DELAY, ST_PAD: begin
                    sdata <= 1'b0;
                end
                ST_SHIFT: begin
                    if (lr_edge || state != ST_SHIFT) begin
                        bit_idx <= MSB_IDX;
                        sdata   <= word_now[MSB_IDX];
                    end else begin
                        bit_idx <= bit_idx - 1'b1;
                        sdata   <= word_now[bit_idx - 1'b1];
                    end
                end
            endcase
        end
    end

    assign state_o   = state;
    assign sclk_ev_o = ev;

endmodule

// File: rtl/audio_ser_top.sv
module audio_ser_top
    import audio_ser_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_in,
    input  logic                lrck_in,
    input  logic                fmt_strap,
    input  logic                pair_valid,
    input  logic [SAMPLE_W-1:0] pair_left,
    input  logic [SAMPLE_W-1:0] pair_right,
    output logic                sdata_out
);

    logic [1:0] clk_sync;
    logic       fmt_valid, fmt_i2s;
    logic       sclk_ev;
    ser_state_t cur_state;

    audio_ser_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({lrck_in, sclk_in}),
        .sync_out (clk_sync)
    );

    audio_ser_fmt_latch u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (fmt_strap),
        .fmt_valid (fmt_valid),
        .fmt_i2s   (fmt_i2s)
    );

    audio_ser_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (clk_sync[0]),
        .lrck_s     (clk_sync[1]),
        .fmt_valid  (fmt_valid),
        .fmt_i2s    (fmt_i2s),
        .pair_valid (pair_valid),
        .pair_left  (pair_left),
        .pair_right (pair_right),
        .sdata      (sdata_out),
        .state_o    (cur_state),
        .sclk_ev_o  (sclk_ev)
    );

endmodule

// File: rtl/audio_ser_checker.sv
module audio_ser_checker
    import audio_ser_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sdata,
    input ser_state_t state,
    input logic       sclk_ev,
    input logic       fmt_valid,
    input logic       fmt_i2s
);

    p_change_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $past(sclk_ev));

    p_strap_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_valid && $past(fmt_valid)) |-> $stable(fmt_i2s));

    p_strap_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_valid |=> fmt_valid);

    p_pad_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |-> !sdata);

    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sdata);

    p_delay_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY) |-> (!sdata && fmt_i2s));

endmodule

bind audio_ser_top audio_ser_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdata     (sdata_out),
    .state     (cur_state),
    .sclk_ev   (sclk_ev),
    .fmt_valid (fmt_valid),
    .fmt_i2s   (fmt_i2s)
);

// File: tb/audio_ser_top_test.sv
module audio_ser_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int SLOT       = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b1;
    logic        lrck_in = 1'b1;
    logic        fmt_strap = 1'b1;
    logic        pair_valid = 1'b0;
    logic [23:0] pair_left = '0;
    logic [23:0] pair_right = '0;
    logic        sdata_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural model state
    bit          m_fmt;
    bit          m_seen, m_started, m_left, m_prev;
    int          m_k;
    logic [23:0] m_hl, m_hr, m_al, m_ar;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_ser_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_in    (sclk_in),
        .lrck_in    (lrck_in),
        .fmt_strap  (fmt_strap),
        .pair_valid (pair_valid),
        .pair_left  (pair_left),
        .pair_right (pair_right),
        .sdata_out  (sdata_out)
    );

    task automatic check(input logic exp, input string tag);
        checks++;
        if (sdata_out !== exp) begin
            fails++;
            $display("FAIL %s: sdata_out=%b expected=%b at %0t", tag, sdata_out, exp, $time);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        fmt_strap = strap;
        sclk_in = 1'b1;
        lrck_in = strap ? 1'b1 : 1'b0;   // start in the right-slot level
        m_fmt = strap;
        m_seen = 0; m_started = 0; m_left = 0; m_prev = 0; m_k = 0;
        m_hl = '0; m_hr = '0; m_al = '0; m_ar = '0;
        repeat (3) @(negedge clk);
        check(1'b0, "R9");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        fmt_strap = ~strap;              // late strap change must be ignored (R2)
        check(1'b0, "R9");
    endtask

    task automatic offer_pair(input logic [23:0] l, input logic [23:0] r);
        pair_left = l;
        pair_right = r;
        pair_valid = 1'b1;
        @(negedge clk);
        pair_valid = 1'b0;
        m_hl = l;
        m_hr = r;
    endtask

    task automatic bit_period(input logic lr, input string tag);
        logic        exp;
        logic [23:0] w;
        string       t;
        @(negedge clk);
        sclk_in = 1'b0;
        lrck_in = lr;
        if (!m_seen) begin
            m_seen = 1;
            m_prev = lr;
        end else if (lr != m_prev) begin
            m_prev = lr;
            m_k = 0;
            m_started = 1;
            m_left = m_fmt ? !lr : lr;
            if (m_left) begin
                m_al = m_hl;
                m_ar = m_hr;
            end
        end else begin
            m_k++;
        end
        w = m_left ? m_al : m_ar;
        t = tag;
        if (!m_started) begin
            exp = 1'b0; t = "R9";
        end else if (m_fmt) begin
            if (m_k == 0) begin exp = 1'b0; t = "R5"; end
            else if (m_k <= 24) exp = w[24 - m_k];
            else begin exp = 1'b0; t = "R6"; end
        end else begin
            if (m_k == 0) begin exp = w[23]; t = "R4"; end
            else if (m_k < 24) exp = w[23 - m_k];
            else begin exp = 1'b0; t = "R6"; end
        end
        repeat (HALF) @(negedge clk);
        check(exp, t);
        sclk_in = 1'b1;
        repeat (HALF - 1) @(negedge clk);
        check(exp, "R10");
    endtask

    task automatic run_frame(input string tag, input bit new_pair,
                             input logic [23:0] nl, input logic [23:0] nr);
        logic left_lvl;
        left_lvl = m_fmt ? 1'b0 : 1'b1;
        for (int i = 0; i < SLOT; i++) bit_period(left_lvl, tag);
        if (new_pair) offer_pair(nl, nr);
        for (int i = 0; i < SLOT; i++) bit_period(!left_lvl, tag);
    endtask

    initial begin
        // Delayed framing run, with the strap flipped after start-up
        do_reset(1'b1);
        offer_pair(24'hA5C3F1, 24'h5A3C0F);
        for (int i = 0; i < 4; i++) bit_period(1'b1, "R9");
        run_frame("R1", 1'b1, 24'h800001, 24'h7FFFFE);   // R7: mid-frame pair waits
        run_frame("R7", 1'b0, '0, '0);
        run_frame("R8", 1'b0, '0, '0);                   // repeat of previous pair
        run_frame("R2", 1'b1, 24'hFFFFFF, 24'h000000);
        run_frame("R3", 1'b0, '0, '0);

        // Left-justified run
        do_reset(1'b0);
        offer_pair(24'h123456, 24'hFEDCBA);
        for (int i = 0; i < 4; i++) bit_period(1'b0, "R9");
        run_frame("R1", 1'b1, 24'hC00003, 24'h3FFFFC);
        run_frame("R7", 1'b0, '0, '0);
        run_frame("R8", 1'b0, '0, '0);
        run_frame("R3", 1'b0, '0, '0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule